// File: doc/BRIEF.md
# Label-Filtered Receive FIFO

This block sits behind a serial word decoder and in front of a 16-bit host bus. Each time the decoder strobes a complete 32-bit word, the block runs two optional acceptance tests. One compares the label (word bits 1 to 8) against a 16-entry programmable label table. The other compares word bits 9 and 10 against two configured values. A word that passes every enabled test is stored in a 32-word FIFO. A rejected word leaves no trace.

The host reads the oldest word as two 16-bit halves, selected by a half-select input. The word leaves the FIFO only when its upper half is read. Three flags report the fill level: data ready, half full and full. When the FIFO is full, a newly accepted word replaces the most recently stored entry instead of being dropped.

A label-mode input gives the host access to the label table. Each rising edge of this input restarts a 16-step write sequence and a 16-step read sequence. Word reception is suspended while label mode is high. Master reset empties the FIFO and clears the flags, but the label table keeps its contents.

Top module: `label_rx_fifo`

## Requirements
- R1: With `lbl_en_i` high, a strobed word is stored only if `word_i[7:0]` (word bits 1..8, bit 1 in `word_i[0]`) equals one of the 16 table entries. An entry of 0x00 matches a 0x00 label like any other value. With `lbl_en_i` low, the label has no effect.
- R2: With `dec_en_i` high, a word is stored only if `word_i[9:8]` equals `dec_bits_i[1:0]` (`word_i[8]` is word bit 9). When both tests are enabled, both must pass. A disabled test always passes.
- R3: A rejected word changes no flag and no FIFO content.
- R4: Each cycle in which `lbl_mode_i` is low resets the label write position to entry 0. While `lbl_mode_i` is high, each `lbl_wr_i` pulse stores `lbl_wdata_i` into the next entry, and writes after the 16th are ignored. While `lbl_mode_i` is high, `eos_i` is ignored.
- R5: While `lbl_mode_i` is high, each `rd_i` pulse returns the next table entry (entry 0 first) in `rdata_o[7:0]`, with `rdata_o[15:8]` zero. Reads after the 16th return zero. These reads never pop the FIFO. The read position restarts like the write position in R4.
- R6: An accepted word that arrives while the FIFO holds 32 words overwrites the newest entry, and the count stays 32. If a pop happens in the same cycle, the word is appended normally.
- R7: `ready_o` is high when the FIFO holds at least one word, `half_o` when it holds 16 or more, and `full_o` when it holds 32.
- R8: With `map_rev_i` low, the lower half is word bits 16..1 on `rdata_o[15:0]` and the upper half is bits 32..17. With `map_rev_i` high, the lower half carries bit 1 on `rdata_o[7]` through bit 8 on `rdata_o[0]`, with `rdata_o[15:8]` unchanged. The upper half is the same in both mappings.
- R9: A read with `lbl_mode_i` low registers the selected half (`half_sel_i` 0 = lower, 1 = upper) of the oldest word into `rdata_o` on the next clock edge. `rdata_o` holds its value between reads. Only an upper-half read pops the word. A read of an empty FIFO returns zero.
- R10: Asserting `rst_ni` low empties the FIFO, clears all flags, clears `rdata_o` and restarts both label positions. The label table keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| eos_i | input | 1 | One-cycle strobe marking a complete received word |
| word_i | input | 32 | Received word; word bit n is on `word_i[n-1]` |
| lbl_en_i | input | 1 | Enables label filtering |
| dec_en_i | input | 1 | Enables the bit 9/10 test |
| dec_bits_i | input | 2 | Required values of word bits 10 and 9 |
| map_rev_i | input | 1 | Selects the bus mapping of the lower half |
| lbl_mode_i | input | 1 | Label-table access mode |
| lbl_wr_i | input | 1 | Label write pulse |
| lbl_wdata_i | input | 8 | Label write data |
| rd_i | input | 1 | Host read pulse |
| half_sel_i | input | 1 | Half select: 0 = lower, 1 = upper |
| rdata_o | output | 16 | Registered read data |
| ready_o | output | 1 | FIFO not empty |
| half_o | output | 1 | FIFO holds 16 or more words |
| full_o | output | 1 | FIFO holds 32 words |

## Verification
The assertions assume that `eos_i`, `rd_i` and `lbl_wr_i` are single-cycle pulses. They also assume that `lbl_mode_i` changes only while no strobe is active. The bench drives every input one time unit after a rising edge and holds it for the whole cycle, so each pulse covers exactly one edge. The label table is loaded before any stimulus enables label filtering, and filtering is switched off for every readback sequence.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int LBL_W  = 8;
  localparam int LBL_N  = 16;

  // Bus view of one half. rev mirrors the label byte in the lower half.
  function automatic logic [HALF_W-1:0] bus_half(input logic [WORD_W-1:0] w,
                                                 input logic hi, input logic rev);
    logic [HALF_W-1:0] h;
    h = hi ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    if (rev && !hi) begin
      for (int b = 0; b < LBL_W; b++) h[b] = w[LBL_W-1-b];
    end
    return h;
  endfunction
endpackage

// File: rtl/lrf_label_mem.sv
module lrf_label_mem #(
  parameter int N = 16,
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  input  logic [W-1:0] key_i,
  output logic         hit_o,
  output logic [W-1:0] rlabel_o
);
  localparam int AW = $clog2(N);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [N];
  logic [CW-1:0] wcnt_q, rcnt_q;
  logic [N-1:0]  hits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else if (!mode_i) begin
      wcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      if (wr_i && wcnt_q < CW'(N)) wcnt_q <= wcnt_q + CW'(1);
      if (rd_i && rcnt_q < CW'(N)) rcnt_q <= rcnt_q + CW'(1);
    end
  end

  // table is not reset: survives master reset
  always_ff @(posedge clk_i) begin
    if (mode_i && wr_i && wcnt_q < CW'(N)) mem[wcnt_q[AW-1:0]] <= wdata_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = (mem[g] == key_i);
  end

  assign hit_o    = |hits;
  assign rlabel_o = (rcnt_q < CW'(N)) ? mem[rcnt_q[AW-1:0]] : '0;

  AST_WPOS_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= CW'(N) && rcnt_q <= CW'(N)); // R4
  AST_POS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> (wcnt_q == '0 && rcnt_q == '0)); // R4
endmodule

// File: rtl/lrf_fifo.sv
module lrf_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, widx;
  logic [CW-1:0] cnt_q;
  logic          do_pop, ovw, adv;

  assign do_pop = pop_i && (cnt_q != '0);
  // full with no pop: replace newest entry
  assign ovw  = push_i && (cnt_q == CW'(DEPTH)) && !do_pop;
  assign adv  = push_i && !ovw;
  assign widx = ovw ? (wptr_q - AW'(1)) : wptr_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[widx] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (adv)    wptr_q <= wptr_q + AW'(1);
      if (do_pop) rptr_q <= rptr_q + AW'(1);
      cnt_q <= cnt_q + CW'(adv) - CW'(do_pop);
    end
  end

  assign head_o  = mem[rptr_q];
  assign count_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R6
  AST_FULL_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && cnt_q == CW'(DEPTH)) |=> cnt_q == CW'(DEPTH)); // R6
  AST_POP_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CW'(1)); // R9
endmodule

// File: rtl/label_rx_fifo.sv
module label_rx_fifo
  import lrf_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eos_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              lbl_en_i,
  input  logic              dec_en_i,
  input  logic [1:0]        dec_bits_i,
  input  logic              map_rev_i,
  input  logic              lbl_mode_i,
  input  logic              lbl_wr_i,
  input  logic [LBL_W-1:0]  lbl_wdata_i,
  input  logic              rd_i,
  input  logic              half_sel_i,
  output logic [HALF_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              half_o,
  output logic              full_o
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic              hit, lbl_ok, dec_ok, accept, pop_req;
  logic [LBL_W-1:0]  lbl_rd;
  logic [WORD_W-1:0] head;
  logic [CW-1:0]     cnt;
  logic [HALF_W-1:0] rdata_q;

  lrf_label_mem #(.N(LBL_N), .W(LBL_W)) u_lbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (lbl_mode_i),
    .wr_i     (lbl_wr_i),
    .wdata_i  (lbl_wdata_i),
    .rd_i     (rd_i),
    .key_i    (word_i[LBL_W-1:0]),
    .hit_o    (hit),
    .rlabel_o (lbl_rd)
  );

  assign lbl_ok  = !lbl_en_i || hit;
  assign dec_ok  = !dec_en_i || (word_i[9:8] == dec_bits_i);
  assign accept  = eos_i && !lbl_mode_i && lbl_ok && dec_ok;
  assign pop_req = rd_i && half_sel_i && !lbl_mode_i;

  lrf_fifo #(.DW(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .pop_i   (pop_req),
    .wdata_i (word_i),
    .head_o  (head),
    .count_o (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      if (lbl_mode_i)     rdata_q <= {{(HALF_W-LBL_W){1'b0}}, lbl_rd};
      else if (cnt != '0) rdata_q <= bus_half(head, half_sel_i, map_rev_i);
      else                rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;
  assign ready_o = (cnt != '0);
  assign half_o  = (cnt >= CW'(DEPTH / 2));
  assign full_o  = (cnt == CW'(DEPTH));

  AST_REJECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && !accept && !rd_i) |=> $stable(cnt)); // R3
  AST_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lbl_mode_i |=> $stable(cnt)); // R4
  AST_LOW_HALF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !half_sel_i && !eos_i) |=> $stable(cnt)); // R9
  AST_FLAG_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (half_o && ready_o)); // R7
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R9
endmodule

// File: tb/sim_label_rx_fifo.sv
module sim_label_rx_fifo;
  localparam int CLK_T = 10;

  logic        clk = 0, rst_n = 0;
  logic        eos = 0, lbl_en = 0, dec_en = 0, map_rev = 0;
  logic        lbl_mode = 0, lbl_wr = 0, rd = 0, half_sel = 0;
  logic [31:0] word = '0;
  logic [1:0]  dec_bits = '0;
  logic [7:0]  lbl_wdata = '0;
  logic [15:0] rdata;
  logic        ready, half, full;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  bit [31:0] q[$];
  bit [7:0]  lab[16];
  int        wc = 0, rc = 0;
  bit [15:0] exp_rd = '0;

  always #(CLK_T/2) clk = ~clk;

  label_rx_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .eos_i(eos), .word_i(word),
    .lbl_en_i(lbl_en), .dec_en_i(dec_en), .dec_bits_i(dec_bits),
    .map_rev_i(map_rev), .lbl_mode_i(lbl_mode), .lbl_wr_i(lbl_wr),
    .lbl_wdata_i(lbl_wdata), .rd_i(rd), .half_sel_i(half_sel),
    .rdata_o(rdata), .ready_o(ready), .half_o(half), .full_o(full)
  );

  task automatic check(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      summary();
    end
  end

  function automatic bit [15:0] ref_half(bit [31:0] w, bit hi, bit rev);
    bit [15:0] r;
    if (hi) return w >> 16;
    r = w & 32'hFFFF;
    if (rev) for (int i = 0; i < 8; i++) r[7-i] = w[i];
    return r;
  endfunction

  function automatic bit in_table(bit [7:0] l);
    foreach (lab[i]) if (lab[i] == l) return 1;
    return 0;
  endfunction

  task automatic cmp_flags(string tag);
    check({tag, "/R7"}, "ready", ready, q.size() > 0);
    check({tag, "/R7"}, "half",  half,  q.size() >= 16);
    check({tag, "/R7"}, "full",  full,  q.size() == 32);
  endtask

  task automatic tick(string tag);
    bit acc, did_rd;
    @(posedge clk);
    #1;
    did_rd = rd;
    if (rd) begin
      if (lbl_mode) exp_rd = (rc < 16) ? 16'(lab[rc]) : 16'h0;
      else          exp_rd = (q.size() > 0) ? ref_half(q[0], half_sel, map_rev) : 16'h0;
    end
    acc = eos && !lbl_mode && (!lbl_en || in_table(word[7:0])) &&
          (!dec_en || word[9:8] == dec_bits);
    if (lbl_mode) begin
      if (lbl_wr && wc < 16) begin lab[wc] = lbl_wdata; wc++; end
      if (rd && rc < 16) rc++;
    end else begin
      wc = 0; rc = 0;
    end
    if (rd && half_sel && !lbl_mode && q.size() > 0) void'(q.pop_front());
    if (acc) begin
      if (q.size() < 32) q.push_back(word);
      else q[31] = word;
    end
    cmp_flags(tag);
    if (did_rd) check(tag, "rdata", rdata, exp_rd);
  endtask

  task automatic send(bit [31:0] w, string tag);
    eos = 1; word = w; tick(tag); eos = 0;
  endtask

  task automatic hread(bit hi, string tag);
    rd = 1; half_sel = hi; tick(tag); rd = 0;
  endtask

  task automatic lwrite(bit [7:0] d, string tag);
    lbl_wr = 1; lbl_wdata = d; tick(tag); lbl_wr = 0;
  endtask

  task automatic do_reset(string tag);
    rst_n = 0;
    @(posedge clk);
    #1;
    q.delete(); wc = 0; rc = 0; exp_rd = '0;
    cmp_flags(tag);
    check(tag, "rdata", rdata, 0);
    rst_n = 1;
  endtask

  function automatic bit [31:0] mk(int i, bit [7:0] l, bit [1:0] b910);
    bit [31:0] w;
    w = 32'h9E3779B1 * (i + 3);
    w[7:0] = l;
    w[9:8] = b910;
    return w;
  endfunction

  initial begin
    do_reset("R10_init");
    tick("R10_idle");

    // load table
    lbl_mode = 1;
    for (int k = 0; k < 16; k++) lwrite((k == 3) ? 8'h00 : 8'(k * 13 + 5), "R4_load");
    lwrite(8'hEE, "R4_extra_ignored");
    send(32'h1234_5678, "R4_eos_suspended");
    lbl_mode = 0; tick("R4_exit");

    // readback, one past the end
    lbl_mode = 1;
    for (int k = 0; k < 17; k++) hread(1, "R5_readback");
    lbl_mode = 0; tick("R5_exit");

    // label filter
    lbl_en = 1;
    send(mk(1, 8'h00, 2'b00), "R1_zero_label");
    send(mk(2, 8'h46, 2'b11), "R1_match");
    send(mk(3, 8'hFF, 2'b01), "R3_reject_label");
    send(mk(4, 8'h2C, 2'b00), "R3_reject_label2");

    // bits 9/10
    dec_en = 1; dec_bits = 2'b10;
    send(mk(5, 8'h05, 2'b10), "R2_both_pass");
    send(mk(6, 8'h05, 2'b01), "R2_dec_fail");
    send(mk(7, 8'hFF, 2'b10), "R2_lbl_fail");
    lbl_en = 0;
    send(mk(8, 8'hFF, 2'b10), "R2_dec_only");
    send(mk(9, 8'hFF, 2'b00), "R2_dec_only_fail");
    dec_en = 0;

    // reads and mappings
    map_rev = 0;
    hread(0, "R9_low");
    hread(0, "R9_low_again");
    tick("R9_hold");
    hread(1, "R9_high_pop");
    map_rev = 1;
    hread(0, "R8_rev_low");
    hread(1, "R8_rev_high");
    map_rev = 0;
    while (q.size() > 0) begin hread(0, "R8_drain"); hread(1, "R8_drain"); end
    hread(0, "R9_empty_low");
    hread(1, "R9_empty_high");

    // fill beyond capacity
    for (int i = 0; i < 34; i++) send(mk(20 + i, 8'(i), 2'(i)), "R6_fill");
    eos = 1; word = mk(99, 8'h77, 2'b11); rd = 1; half_sel = 1;
    tick("R6_full_push_pop");
    eos = 0; rd = 0;
    for (int i = 0; i < 33; i++) begin
      map_rev = i[0];
      hread(0, "R6_drain"); hread(1, "R6_drain");
    end

    // reset keeps labels
    for (int i = 0; i < 5; i++) send(mk(60 + i, 8'h11, 2'b00), "R10_prefill");
    lbl_mode = 1;
    lwrite(8'h5A, "R10_partial_write");
    do_reset("R10_reset");
    tick("R10_after");
    lbl_mode = 0; tick("R10_exit");
    lbl_mode = 1;
    for (int k = 0; k < 16; k++) hread(0, "R10_labels_kept");
    lbl_mode = 0; tick("R10_done");

    summary();
  end
endmodule